// File: doc/BRIEF.md
# Branch Target Buffer with Condition-Register Prediction

This block is a direct-mapped branch target buffer for a fetch unit. Each entry records a tag, a branch target, and two 2-bit saturating counters. It also records the number of the register that holds the branch's condition predicate. A fetch-address lookup returns hit, target and a predicted direction one cycle later. During that response cycle the block reads the live value of the recorded condition register through a side port to the register file.

A mode input selects how that live value is used. In condition-only mode the predicate value is the prediction. In select mode the predicate chooses one of the entry's two counters, and that counter's upper bit is the prediction. This lets compiler-computed predicates either override the hardware history or steer it.

A resolve port takes the branch address, the outcome, the target, the condition register number and the predicate value that was seen. A hit trains one counter. A taken miss allocates the entry.

Top module: `creg_btb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid_o` is 0, and every lookup misses until an allocation has taken place.
- R2: A lookup with `lk_valid_i` high gives `rsp_valid_o` high in the next cycle, and only then. On a hit, `rsp_target_o` is the stored target.
- R3: On a miss or with no response, `rsp_hit_o`, `rsp_taken_o` and `rsp_target_o` are all 0, so fetch continues sequentially.
- R4: The index is bits [IDX_W+1:2] of the address. The tag is all other address bits. Two addresses with the same index and different tags never hit on each other's entry.
- R5: A resolve that misses with outcome taken allocates the entry. It writes tag, target and condition register number, and sets both counters to 2.
- R6: A resolve that misses with outcome not-taken writes nothing.
- R7: In the response cycle of a hit, `rf_raddr_o` carries the stored condition register number. On a miss it is 0.
- R8: With mode 0 (condition-only) captured at lookup, a hit predicts exactly the live value of `rf_rdata_i`.
- R9: With mode 1 (select) captured at lookup, a hit predicts taken when the counter picked by `rf_rdata_i` (counter 0 for 0, counter 1 for 1) holds 2 or 3.
- R10: A resolve that hits steps only the counter picked by `upd_cond_i`. Taken increments it and not-taken decrements it, saturating at 3 and 0. The other counter is unchanged.
- R11: A resolve that hits always rewrites the condition register number. It rewrites the target only when the outcome is taken.
- R12: A lookup and a resolve to the same index in the same cycle: the lookup sees the contents from before the resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Prediction mode, captured with the lookup: 0 condition-only, 1 select |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | ADDR_W | Fetch address to look up |
| rsp_valid_o | output | 1 | Response valid, one cycle after the lookup |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_target_o | output | ADDR_W | Predicted target, 0 on a miss |
| rsp_taken_o | output | 1 | Predicted direction |
| rf_raddr_o | output | CREG_W | Condition register number read in the response cycle |
| rf_rdata_i | input | 1 | Live predicate value of that register |
| upd_valid_i | input | 1 | Resolve request |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_target_i | input | ADDR_W | Resolved target |
| upd_creg_i | input | CREG_W | Condition register number of the branch |
| upd_cond_i | input | 1 | Predicate value that selected the counter |

## Verification
The bench builds the buffer with 16 entries, 16-bit addresses and an 8-register predicate file. With so few entries, three tags per index produce constant aliasing and eviction. Lookups and resolves often land on the same index in the same cycle, so ordering is exercised. A counter can be walked to both saturation limits within a few resolves. Directed sequences cover allocation, the no-allocate case, and both rails of each counter in both modes. A long random phase then switches the mode every few hundred cycles.

// File: rtl/creg_btb_pkg.sv
package creg_btb_pkg;

  typedef enum logic {
    PMODE_COND   = 1'b0,
    PMODE_SELECT = 1'b1
  } pmode_e;

  localparam int unsigned NUM_BANKS = 2;
  localparam logic [1:0]  CTR_ALLOC = 2'd2;

  function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_dir(input logic [1:0] c);
    return c[1];
  endfunction

endpackage

// File: rtl/creg_btb_split.sv
module creg_btb_split #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned ALIGN_W = 2,
  localparam int unsigned TAG_W  = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int unsigned HI_LSB = ALIGN_W + IDX_W;

  assign idx_o = pc_i[ALIGN_W +: IDX_W];
  // tag keeps every non-index bit, including the alignment bits
  assign tag_o = {pc_i[ADDR_W-1:HI_LSB], pc_i[ALIGN_W-1:0]};
endmodule

// File: rtl/creg_btb_store.sv
module creg_btb_store
  import creg_btb_pkg::*;
#(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned TAG_W   = 22,
  parameter int unsigned TGT_W   = 32,
  parameter int unsigned CREG_W  = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  // registered read for lookup
  input  logic                           rd_en_i,
  input  logic [IDX_W-1:0]               rd_idx_i,
  output logic                           rd_valid_o,
  output logic [TAG_W-1:0]               rd_tag_o,
  output logic [TGT_W-1:0]               rd_tgt_o,
  output logic [CREG_W-1:0]              rd_creg_o,
  output logic [NUM_BANKS-1:0][1:0]      rd_ctr_o,
  // combinational probe for resolve
  input  logic [IDX_W-1:0]               pr_idx_i,
  output logic                           pr_valid_o,
  output logic [TAG_W-1:0]               pr_tag_o,
  output logic [NUM_BANKS-1:0][1:0]      pr_ctr_o,
  // write port
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic                           wr_alloc_i,
  input  logic [TAG_W-1:0]               wr_tag_i,
  input  logic                           wr_tgt_we_i,
  input  logic [TGT_W-1:0]               wr_tgt_i,
  input  logic                           wr_creg_we_i,
  input  logic [CREG_W-1:0]              wr_creg_i,
  input  logic [NUM_BANKS-1:0]           wr_ctr_we_i,
  input  logic [NUM_BANKS-1:0][1:0]      wr_ctr_i
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [TGT_W-1:0]   tgt_q  [ENTRIES];
  logic [CREG_W-1:0]  creg_q [ENTRIES];

  logic               rd_valid_q;
  logic [TAG_W-1:0]   rd_tag_q;
  logic [TGT_W-1:0]   rd_tgt_q;
  logic [CREG_W-1:0]  rd_creg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_alloc_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_alloc_i)   tag_q[wr_idx_i]  <= wr_tag_i;
    if (wr_tgt_we_i)  tgt_q[wr_idx_i]  <= wr_tgt_i;
    if (wr_creg_we_i) creg_q[wr_idx_i] <= wr_creg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else if (rd_en_i) rd_valid_q <= valid_q[rd_idx_i];
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_tag_q  <= tag_q[rd_idx_i];
      rd_tgt_q  <= tgt_q[rd_idx_i];
      rd_creg_q <= creg_q[rd_idx_i];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [1:0] ctr_q [ENTRIES];
    logic [1:0] rd_ctr_q;

    always_ff @(posedge clk_i) begin
      if (wr_ctr_we_i[b]) ctr_q[wr_idx_i] <= wr_ctr_i[b];
    end

    always_ff @(posedge clk_i) begin
      if (rd_en_i) rd_ctr_q <= ctr_q[rd_idx_i];
    end

    assign rd_ctr_o[b] = rd_ctr_q;
    assign pr_ctr_o[b] = ctr_q[pr_idx_i];

    // R5: a fresh allocation leaves each counter weakly taken
    p_alloc_ctr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_alloc_i |=> ctr_q[$past(wr_idx_i)] == CTR_ALLOC);
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_tag_o   = rd_tag_q;
  assign rd_tgt_o   = rd_tgt_q;
  assign rd_creg_o  = rd_creg_q;

  assign pr_valid_o = valid_q[pr_idx_i];
  assign pr_tag_o   = tag_q[pr_idx_i];

  p_alloc_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_alloc_i |=> valid_q[$past(wr_idx_i)]);

  p_valid_monotone_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_alloc_i |=> valid_q == $past(valid_q));

endmodule

// File: rtl/creg_btb_update.sv
module creg_btb_update
  import creg_btb_pkg::*;
#(
  parameter int unsigned TAG_W = 22
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      upd_valid_i,
  input  logic [TAG_W-1:0]          upd_tag_i,
  input  logic                      upd_taken_i,
  input  logic                      upd_cond_i,
  input  logic                      pr_valid_i,
  input  logic [TAG_W-1:0]          pr_tag_i,
  input  logic [NUM_BANKS-1:0][1:0] pr_ctr_i,
  output logic                      alloc_o,
  output logic                      tgt_we_o,
  output logic                      creg_we_o,
  output logic [NUM_BANKS-1:0]      ctr_we_o,
  output logic [NUM_BANKS-1:0][1:0] ctr_wd_o
);

  logic upd_hit;

  assign upd_hit   = upd_valid_i && pr_valid_i && (pr_tag_i == upd_tag_i);
  assign alloc_o   = upd_valid_i && !upd_hit && upd_taken_i;
  assign tgt_we_o  = alloc_o || (upd_hit && upd_taken_i);
  assign creg_we_o = alloc_o || upd_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ctr
    assign ctr_we_o[b] = alloc_o || (upd_hit && (upd_cond_i == b[0]));
    assign ctr_wd_o[b] = alloc_o ? CTR_ALLOC : ctr_next(pr_ctr_i[b], upd_taken_i);
  end

  p_one_bank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_o |-> $onehot0(ctr_we_o));

  p_nt_miss_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |-> !alloc_o && !tgt_we_o);

endmodule

// File: rtl/creg_btb_predict.sv
module creg_btb_predict
  import creg_btb_pkg::*;
#(
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned TGT_W  = 32,
  parameter int unsigned CREG_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rsp_i,
  input  pmode_e                    mode_i,
  input  logic [TAG_W-1:0]          lk_tag_i,
  input  logic                      ent_valid_i,
  input  logic [TAG_W-1:0]          ent_tag_i,
  input  logic [TGT_W-1:0]          ent_tgt_i,
  input  logic [CREG_W-1:0]         ent_creg_i,
  input  logic [NUM_BANKS-1:0][1:0] ent_ctr_i,
  input  logic                      rf_rdata_i,
  output logic                      hit_o,
  output logic                      taken_o,
  output logic [TGT_W-1:0]          target_o,
  output logic [CREG_W-1:0]         rf_raddr_o
);

  logic sel_dir;

  assign hit_o      = rsp_i && ent_valid_i && (ent_tag_i == lk_tag_i);
  assign rf_raddr_o = hit_o ? ent_creg_i : '0;
  assign target_o   = hit_o ? ent_tgt_i : '0;
  assign sel_dir    = ctr_dir(ent_ctr_i[rf_rdata_i]);

  always_comb begin
    taken_o = 1'b0;
    if (hit_o) begin
      unique case (mode_i)
        PMODE_COND:   taken_o = rf_rdata_i;
        PMODE_SELECT: taken_o = sel_dir;
        default:      taken_o = 1'b0;
      endcase
    end
  end

  p_miss_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> !taken_o && (target_o == '0) && (rf_raddr_o == '0));

endmodule

// File: rtl/creg_btb.sv
module creg_btb
  import creg_btb_pkg::*;
#(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CREG_W  = 6,
  parameter int unsigned ALIGN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [ADDR_W-1:0] rsp_target_o,
  output logic              rsp_taken_o,
  output logic [CREG_W-1:0] rf_raddr_o,
  input  logic              rf_rdata_i,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [CREG_W-1:0] upd_creg_i,
  input  logic              upd_cond_i
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, upd_tag;

  creg_btb_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_split_lk (
    .pc_i(lk_pc_i), .idx_o(lk_idx), .tag_o(lk_tag)
  );

  creg_btb_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_split_upd (
    .pc_i(upd_pc_i), .idx_o(upd_idx), .tag_o(upd_tag)
  );

  // lookup stage
  logic             rsp_q;
  logic [TAG_W-1:0] lk_tag_q;
  pmode_e           mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q    <= 1'b0;
      lk_tag_q <= '0;
      mode_q   <= PMODE_COND;
    end else begin
      rsp_q <= lk_valid_i;
      if (lk_valid_i) begin
        lk_tag_q <= lk_tag;
        mode_q   <= pmode_e'(mode_i);
      end
    end
  end

  logic                      rd_valid, pr_valid;
  logic [TAG_W-1:0]          rd_tag, pr_tag;
  logic [ADDR_W-1:0]         rd_tgt;
  logic [CREG_W-1:0]         rd_creg;
  logic [NUM_BANKS-1:0][1:0] rd_ctr, pr_ctr, ctr_wd;
  logic [NUM_BANKS-1:0]      ctr_we;
  logic                      alloc, tgt_we, creg_we;

  creg_btb_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(ADDR_W), .CREG_W(CREG_W)
  ) u_store (
    .clk_i, .rst_ni,
    .rd_en_i(lk_valid_i), .rd_idx_i(lk_idx),
    .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_tgt_o(rd_tgt),
    .rd_creg_o(rd_creg), .rd_ctr_o(rd_ctr),
    .pr_idx_i(upd_idx), .pr_valid_o(pr_valid), .pr_tag_o(pr_tag), .pr_ctr_o(pr_ctr),
    .wr_idx_i(upd_idx), .wr_alloc_i(alloc), .wr_tag_i(upd_tag),
    .wr_tgt_we_i(tgt_we), .wr_tgt_i(upd_target_i),
    .wr_creg_we_i(creg_we), .wr_creg_i(upd_creg_i),
    .wr_ctr_we_i(ctr_we), .wr_ctr_i(ctr_wd)
  );

  creg_btb_update #(.TAG_W(TAG_W)) u_update (
    .clk_i, .rst_ni,
    .upd_valid_i, .upd_tag_i(upd_tag), .upd_taken_i, .upd_cond_i,
    .pr_valid_i(pr_valid), .pr_tag_i(pr_tag), .pr_ctr_i(pr_ctr),
    .alloc_o(alloc), .tgt_we_o(tgt_we), .creg_we_o(creg_we),
    .ctr_we_o(ctr_we), .ctr_wd_o(ctr_wd)
  );

  creg_btb_predict #(.TAG_W(TAG_W), .TGT_W(ADDR_W), .CREG_W(CREG_W)) u_predict (
    .clk_i, .rst_ni,
    .rsp_i(rsp_q), .mode_i(mode_q), .lk_tag_i(lk_tag_q),
    .ent_valid_i(rd_valid), .ent_tag_i(rd_tag), .ent_tgt_i(rd_tgt),
    .ent_creg_i(rd_creg), .ent_ctr_i(rd_ctr),
    .rf_rdata_i,
    .hit_o(rsp_hit_o), .taken_o(rsp_taken_o),
    .target_o(rsp_target_o), .rf_raddr_o(rf_raddr_o)
  );

  assign rsp_valid_o = rsp_q;

  p_rsp_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);

  p_no_spurious_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o);

  p_hit_needs_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);

  p_cond_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o && $past(lk_valid_i) && ($past(mode_i) == 1'b0)) |-> rsp_taken_o == rf_rdata_i);

endmodule

// File: tb/creg_btb_tb.sv
`timescale 1ns/1ps
module creg_btb_tb_top;

  localparam int ENT  = 16;
  localparam int AW   = 16;
  localparam int CW   = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_i = 1'b0;
  logic          lk_valid_i = 1'b0;
  logic [AW-1:0] lk_pc_i = '0;
  logic          rsp_valid_o, rsp_hit_o, rsp_taken_o;
  logic [AW-1:0] rsp_target_o;
  logic [CW-1:0] rf_raddr_o;
  logic          rf_rdata_i;
  logic          upd_valid_i = 1'b0;
  logic [AW-1:0] upd_pc_i = '0;
  logic          upd_taken_i = 1'b0;
  logic [AW-1:0] upd_target_i = '0;
  logic [CW-1:0] upd_creg_i = '0;
  logic          upd_cond_i = 1'b0;
  logic [7:0]    preds = '0;

  always #2 clk_i = ~clk_i;

  assign rf_rdata_i = preds[rf_raddr_o];

  creg_btb #(.ENTRIES(ENT), .ADDR_W(AW), .CREG_W(CW), .ALIGN_W(2)) dut_i (
    .clk_i, .rst_ni, .mode_i, .lk_valid_i, .lk_pc_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_target_o, .rsp_taken_o,
    .rf_raddr_o, .rf_rdata_i,
    .upd_valid_i, .upd_pc_i, .upd_taken_i, .upd_target_i, .upd_creg_i, .upd_cond_i
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  bit m_v[ENT];
  int m_tag[ENT], m_tgt[ENT], m_creg[ENT];
  int m_ctr[ENT][2];

  bit s_pend = 0, s_hit, s_alias, s_same, s_mode;
  int s_tgt, s_creg, s_c0, s_c1;

  function automatic int idx_of(int pc);
    return (pc >> 2) & (ENT - 1);
  endfunction
  function automatic int tag_of(int pc);
    return ((pc >> 6) << 2) | (pc & 3);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int p, c;
    chk("R2", int'(rsp_valid_o), int'(s_pend));
    if (s_pend) begin
      chk(s_alias ? "R4" : (s_same ? "R12" : "R5/R6"), int'(rsp_hit_o), int'(s_hit));
      chk(s_hit ? "R11" : "R3", int'(rsp_target_o), s_hit ? s_tgt : 0);
      chk("R7", int'(rf_raddr_o), s_hit ? s_creg : 0);
      if (!s_hit) chk("R3", int'(rsp_taken_o), 0);
      else begin
        p = int'(preds[s_creg]);
        if (!s_mode) chk("R8", int'(rsp_taken_o), p);
        else begin
          c = p ? s_c1 : s_c0;
          chk("R9/R10", int'(rsp_taken_o), (c >= 2) ? 1 : 0);
        end
      end
    end
  endtask

  task automatic cyc(bit lk, int lpc, bit md, bit up, int upc, bit tk, int utg,
                     int ucr, bit ucd, int pv);
    int li, ui;
    bit uhit;
    compare();
    if (pv >= 0) preds = 8'(pv);
    lk_valid_i   = lk;  lk_pc_i = AW'(lpc); mode_i = md;
    upd_valid_i  = up;  upd_pc_i = AW'(upc); upd_taken_i = tk;
    upd_target_i = AW'(utg); upd_creg_i = CW'(ucr); upd_cond_i = ucd;
    li = idx_of(lpc); ui = idx_of(upc);
    s_pend = lk;
    if (lk) begin
      s_hit   = m_v[li] && (m_tag[li] == tag_of(lpc));
      s_alias = m_v[li] && !s_hit;
      s_same  = up && (ui == li);
      s_mode  = md;
      s_tgt   = m_tgt[li]; s_creg = m_creg[li];
      s_c0    = m_ctr[li][0]; s_c1 = m_ctr[li][1];
    end
    if (up) begin
      uhit = m_v[ui] && (m_tag[ui] == tag_of(upc));
      if (uhit) begin
        m_creg[ui] = ucr;
        if (tk) m_tgt[ui] = utg;
        if (tk) m_ctr[ui][ucd] = (m_ctr[ui][ucd] == 3) ? 3 : m_ctr[ui][ucd] + 1;
        else    m_ctr[ui][ucd] = (m_ctr[ui][ucd] == 0) ? 0 : m_ctr[ui][ucd] - 1;
      end else if (tk) begin
        m_v[ui] = 1; m_tag[ui] = tag_of(upc); m_tgt[ui] = utg; m_creg[ui] = ucr;
        m_ctr[ui][0] = 2; m_ctr[ui][1] = 2;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic look(int pc, bit md, int pv);
    cyc(1, pc, md, 0, 0, 0, 0, 0, 0, pv);
  endtask
  task automatic resolve(int pc, bit tk, int tg, int cr, bit cd);
    cyc(0, 0, 0, 1, pc, tk, tg, cr, cd, -1);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  localparam int PA = 16'h0010;  // idx 4, tag 0
  localparam int PB = 16'h0050;  // idx 4, tag 4 (alias of PA)

  initial begin
    for (int i = 0; i < ENT; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; m_creg[i] = 0;
      m_ctr[i][0] = 0; m_ctr[i][1] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", int'(rsp_valid_o), 0);
    chk("R1", int'(rsp_hit_o), 0);

    // R1: lookups miss before any allocation
    look(PA, 0, 8'h00);
    look(16'h0104, 1, 8'hff);
    // R6: not-taken miss does not allocate
    resolve(PA, 0, 16'h1234, 3, 0);
    look(PA, 0, -1);
    // R5: taken miss allocates
    resolve(PA, 1, 16'h2468, 3, 0);
    look(PA, 0, 8'h08);          // R8 taken via live predicate
    look(PA, 0, 8'h00);          // R8 not taken
    look(PB, 0, -1);             // R4 alias misses
    // R9 select mode, counters start at 2
    look(PA, 1, 8'h00);
    resolve(PA, 0, 0, 3, 0);
    resolve(PA, 0, 0, 3, 0);
    resolve(PA, 0, 0, 3, 0);     // ctr0 saturates at 0
    look(PA, 1, 8'h00);          // ctr0 -> not taken
    look(PA, 1, 8'h08);          // ctr1 untouched -> taken (R10)
    // R10 saturation at 3
    resolve(PA, 1, 16'h2468, 3, 1);
    resolve(PA, 1, 16'h2468, 3, 1);
    resolve(PA, 1, 16'h2468, 3, 1);
    resolve(PA, 0, 16'h9999, 5, 1);
    resolve(PA, 0, 16'h9999, 5, 1);
    look(PA, 1, 8'h20);          // ctr1 = 1, creg 5, target kept (R11)
    resolve(PA, 1, 16'h4444, 5, 0);
    look(PA, 1, 8'h00);          // R11 new target
    // R12 same-cycle lookup and resolve on one index
    cyc(1, PB, 0, 1, PB, 1, 16'h7777, 2, 0, -1);
    look(PB, 0, 8'h04);
    cyc(1, PB, 1, 1, PB, 0, 0, 6, 0, 8'h00);
    look(PB, 1, 8'h00);
    look(PA, 1, -1);             // evicted by PB

    for (int n = 0; n < 4000; n++) begin
      int lpc, upc;
      bit md;
      md  = ((n / 500) % 2) == 1;
      lpc = ((($urandom % 3) << 6) | (($urandom % ENT) << 2));
      upc = ((($urandom % 3) << 6) | (($urandom % ENT) << 2));
      cyc(bit'($urandom % 2), lpc, md, bit'(($urandom % 3) != 0), upc,
          bit'($urandom % 2), int'($urandom % 65536), int'($urandom % 8),
          bit'($urandom % 2), int'($urandom % 256));
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, -1);
    compare();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

endmodule